// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block resolves a relative branch in one clock. It takes the four-bit condition field of a branch instruction, the four arithmetic flags (carry, zero, negative, overflow), the program counter of the branch and its eight-bit signed displacement. From these it returns whether the branch is taken and the program counter of the next instruction.

Every branch is two bytes long. A branch that is not taken falls through to the instruction two bytes on. A taken branch adds the sign-extended displacement to that fall-through address. All address arithmetic wraps modulo 65536.

The sixteen conditions form eight complementary pairs. Each even code names a test, and the odd code above it is the inverse of that test. The pairs cover:
- unconditional and no-operation,
- unsigned magnitude,
- single-flag tests,
- signed magnitude.

Both outputs are registered behind a synchronous active-high reset.

Top module: `bcc_eval`

## Requirements
- R1: While `rst` is high at a clock edge, `taken_o` becomes 0 and `next_pc_o` becomes 0x0000 at that edge.
- R2: The outputs are registered. Inputs sampled at a rising edge appear on `taken_o` and `next_pc_o` after that edge, and the outputs hold their value between edges.
- R3: Condition 0x0 is always taken. Condition 0x1 is never taken: it acts as a no-operation whose next program counter is the fall-through address.
- R4: Condition 0x2 (unsigned higher) is taken when carry and zero are both 0. Condition 0x3 (lower-or-same) is taken otherwise.
- R5: Condition 0x4 is taken when carry is 0, and 0x5 when carry is 1. Condition 0x6 is taken when zero is 0, and 0x7 when zero is 1.
- R6: Condition 0x8 is taken when overflow is 0, and 0x9 when overflow is 1. Condition 0xA is taken when negative is 0, and 0xB when negative is 1.
- R7: Condition 0xC (signed greater-or-equal) is taken when negative equals overflow. Condition 0xD (less-than) is taken when they differ.
- R8: Condition 0xE (signed greater-than) is taken when zero is 0 and negative equals overflow. Condition 0xF (less-or-equal) is taken otherwise.
- R9: For any flags, an odd condition code is taken exactly when the even code one below it is not taken.
- R10: When taken, `next_pc_o` = (`pc_i` + 2 + sign-extended `disp_i`) mod 65536. Bit 7 of `disp_i` is the sign.
- R11: When not taken, `next_pc_o` = (`pc_i` + 2) mod 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Branch condition code, 0x0 to 0xF |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| pc_i | input | 16 | Address of the branch instruction |
| disp_i | input | 8 | Signed branch displacement |
| taken_o | output | 1 | Branch taken, registered |
| next_pc_o | output | 16 | Next program counter, registered |

## Verification
Both results are due exactly one rising edge after the inputs are presented. The bench drives every vector on a falling edge and compares both outputs at the following falling edge. Just after each drive, it also confirms that the outputs still show the previous vector's result, which shows that no path bypasses the register. The sweep covers all sixteen codes against all sixteen flag combinations. Address corners check wrap-around above 0xFFFF and below 0x0000, and the largest forward and backward displacements.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  // Upper three bits of the condition code select a test pair;
  // bit 0 inverts the selected test.
  typedef enum logic [2:0] {
    PAIR_ALWAYS = 3'd0,
    PAIR_UHIGH  = 3'd1,
    PAIR_CARRY0 = 3'd2,
    PAIR_ZERO0  = 3'd3,
    PAIR_OVF0   = 3'd4,
    PAIR_NEG0   = 3'd5,
    PAIR_SGE    = 3'd6,
    PAIR_SGT    = 3'd7
  } cond_pair_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/bcc_cond_eval.sv
module bcc_cond_eval
  import bcc_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              take
);

  logic       base;
  logic       sign_ok;
  cond_pair_e pair;

  assign pair    = cond_pair_e'(cond[COND_W-1:1]);
  assign sign_ok = ~(flags.n ^ flags.v);

  always_comb begin
    unique case (pair)
      PAIR_ALWAYS: base = 1'b1;
      PAIR_UHIGH:  base = ~flags.c & ~flags.z;
      PAIR_CARRY0: base = ~flags.c;
      PAIR_ZERO0:  base = ~flags.z;
      PAIR_OVF0:   base = ~flags.v;
      PAIR_NEG0:   base = ~flags.n;
      PAIR_SGE:    base = sign_ok;
      PAIR_SGT:    base = sign_ok & ~flags.z;
      default:     base = 1'b0;
    endcase
    take = base ^ cond[0];
  end

endmodule

// File: rtl/bcc_target_calc.sv
module bcc_target_calc #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int BR_LEN = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              take,
  output logic [PC_W-1:0]   next_pc
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] jump_pc;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  // Both candidates are formed in parallel; the decision only drives the final mux.
  assign fall_pc = pc + PC_W'(BR_LEN);
  assign jump_pc = fall_pc + disp_ext;
  assign next_pc = take ? jump_pc : fall_pc;

endmodule

// File: rtl/bcc_eval.sv
module bcc_eval
  import bcc_pkg::*;
#(
  parameter int COND_W = 4,
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int BR_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic              flag_n_i,
  input  logic              flag_v_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o
);

  localparam int EXT_W = PC_W - DISP_W;

  flags_t          flags_w;
  logic            take_w;
  logic [PC_W-1:0] npc_w;
  logic            armed_q;

  assign flags_w = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

  bcc_cond_eval #(.COND_W(COND_W)) u_cond (
    .cond  (cond_i),
    .flags (flags_w),
    .take  (take_w)
  );

  bcc_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .BR_LEN(BR_LEN)) u_tgt (
    .pc      (pc_i),
    .disp    (disp_i),
    .take    (take_w),
    .next_pc (npc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      armed_q   <= 1'b0;
    end else begin
      taken_o   <= take_w;
      next_pc_o <= npc_w;
      armed_q   <= 1'b1;
    end
  end

  // armed_q marks that the previous edge was already out of reset.
  p_always_r3: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cond_i) == COND_W'(0)) |-> taken_o);

  p_never_r3: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cond_i) == COND_W'(1)) |-> !taken_o);

  p_uhigh_r4: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cond_i) == COND_W'(2)) |->
      taken_o == (!$past(flag_c_i) && !$past(flag_z_i)));

  p_sge_r7: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cond_i) == COND_W'(12)) |->
      taken_o == ($past(flag_n_i) == $past(flag_v_i)));

  p_sgt_r8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(cond_i) == COND_W'(14)) |->
      taken_o == (!$past(flag_z_i) && ($past(flag_n_i) == $past(flag_v_i))));

  p_fall_r11: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !taken_o) |-> next_pc_o == PC_W'($past(pc_i) + PC_W'(BR_LEN)));

  p_jump_r10: assert property (@(posedge clk) disable iff (rst)
    (armed_q && taken_o) |->
      next_pc_o == PC_W'($past(pc_i) + PC_W'(BR_LEN)
                   + {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

endmodule

// File: tb/sim_bcc_eval.sv
module sim_bcc_eval;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cond_i;
  logic        flag_c_i, flag_z_i, flag_n_i, flag_v_i;
  logic [15:0] pc_i;
  logic [7:0]  disp_i;
  logic        taken_o;
  logic [15:0] next_pc_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic        prev_take;
  logic [15:0] prev_pc;

  always #4 clk = ~clk;

  bcc_eval u0 (
    .clk(clk), .rst(rst), .cond_i(cond_i),
    .flag_c_i(flag_c_i), .flag_z_i(flag_z_i), .flag_n_i(flag_n_i), .flag_v_i(flag_v_i),
    .pc_i(pc_i), .disp_i(disp_i), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Written directly from the requirement list, one code at a time.
  function automatic logic model_take(input logic [3:0] cd, input logic c, input logic z,
                                      input logic n, input logic v);
    case (cd)
      4'h0: return 1'b1;             // R3
      4'h1: return 1'b0;             // R3
      4'h2: return !c && !z;         // R4
      4'h3: return c || z;           // R4
      4'h4: return !c;               // R5
      4'h5: return c;                // R5
      4'h6: return !z;               // R5
      4'h7: return z;                // R5
      4'h8: return !v;               // R6
      4'h9: return v;                // R6
      4'hA: return !n;               // R6
      4'hB: return n;                // R6
      4'hC: return n == v;           // R7
      4'hD: return n != v;           // R7
      4'hE: return !z && (n == v);   // R8
      default: return z || (n != v); // R8
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] cd);
    case (cd[3:1])
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Called just after a falling edge; checks the result at the next falling edge.
  task automatic run(input logic [3:0] cd, input logic [3:0] f,
                     input logic [15:0] pc, input logic [7:0] d);
    logic        et;
    logic [15:0] epc;
    cond_i   = cd;
    flag_c_i = f[0];
    flag_z_i = f[1];
    flag_v_i = f[2];
    flag_n_i = f[3];
    pc_i     = pc;
    disp_i   = d;
    et  = model_take(cd, f[0], f[1], f[3], f[2]);
    epc = et ? 16'(pc + 16'd2 + {{8{d[7]}}, d}) : 16'(pc + 16'd2);
    #1;
    check("R2", "held taken", {15'd0, taken_o}, {15'd0, prev_take});
    check("R2", "held next_pc", next_pc_o, prev_pc);
    @(negedge clk);
    check(req_of(cd), $sformatf("taken cond=%h flags=%h", cd, f), {15'd0, taken_o}, {15'd0, et});
    check(et ? "R10" : "R11", $sformatf("next_pc cond=%h", cd), next_pc_o, epc);
    if (cd[0])
      check("R9", $sformatf("complement cond=%h flags=%h", cd, f), {15'd0, taken_o},
            {15'd0, !model_take(cd & 4'hE, f[0], f[1], f[3], f[2])});
    prev_take = et;
    prev_pc   = epc;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cond_i = 4'h0;
    pc_i = 16'h5A5A;
    disp_i = 8'h10;
    repeat (2) @(negedge clk);
    check("R1", "reset taken", {15'd0, taken_o}, 16'd0);
    check("R1", "reset next_pc", next_pc_o, 16'h0000);
    rst = 1'b0;
    prev_take = 1'b0;
    prev_pc   = 16'h0000;
  endtask

  initial begin
    flag_c_i = 0; flag_z_i = 0; flag_n_i = 0; flag_v_i = 0;
    @(negedge clk);
    do_reset();
    for (int cd = 0; cd < 16; cd++) begin
      for (int f = 0; f < 16; f++) begin
        run(4'(cd), 4'(f), 16'(cd * 4099 + f * 257), 8'(f * 17 + cd * 3));
      end
    end
    run(4'h0, 4'h0, 16'hFFFE, 8'h00);   // R10 wraps to 0x0000
    run(4'h0, 4'h0, 16'hFFF0, 8'h7F);   // R10 largest forward, wraps
    run(4'h0, 4'h0, 16'h0000, 8'h80);   // R10 largest backward, wraps below zero
    run(4'h0, 4'h0, 16'h1234, 8'hFE);   // R10 branch to itself
    run(4'h1, 4'h0, 16'hFFFF, 8'h80);   // R11 never: fall-through wraps
    run(4'h3, 4'h0, 16'hFFFE, 8'h7F);   // R11 not taken wraps
    run(4'hF, 4'h2, 16'h8000, 8'hFF);   // R10 taken with -1
    do_reset();
    run(4'hE, 4'h0, 16'h4000, 8'h40);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule